// File: doc/BRIEF.md
# Byte-Command Bus Master Bridge

This block turns a stream of host bytes into single-byte accesses on a 32-bit pipelined Wishbone master port. It also runs a small 8-bit general-purpose output register and an 8-bit input port. Received bytes arrive over a valid/ready input. Reply bytes leave over a valid/ready output. A host can therefore fill or dump a memory region byte by byte, set the output pins and read the input pins over one byte-wide link.

Every frame opens with a header byte. Its low nibble selects the operation and its high nibble holds bits [11:8] of a byte count. A memory frame follows the header with the low eight bits of the count and then a 32-bit start address. A write frame then carries one data byte per addressed location. A read frame instead returns one byte per location. GPIO frames are shorter, as R7 and R8 describe. The bridge makes one bus access per data byte and waits for its acknowledge before it accepts the next input byte or starts the next access.

Top module: `cmd_bus_bridge`

## Requirements
- R1: After reset, rx_ready_o is 1, tx_valid_o is 0, bus_cyc_o and bus_stb_o are 0 and gpio_o is 8'h00.
- R2: Header byte layout: bits [3:0] are the opcode and bits [7:4] are count bits [11:8]. For memory opcodes the next byte is count bits [7:0]. Four address bytes then follow, most significant first, so counts up to 4095 and all 32 address bits reach the bus.
- R3: Opcode 1 (memory write) accepts exactly count data bytes and stores them at consecutive byte addresses from the start address. The start address may be unaligned.
- R4: Each data byte produces exactly one bus access. bus_adr_o is {addr[31:2],2'b00} and bus_sel_o is the one-hot value 1<<addr[1:0]. On writes the byte is repeated on all four lanes of bus_dat_o.
- R5: Opcode 2 (memory read) returns exactly count bytes on the output stream, in address order. Each byte is taken from lane addr[1:0] of bus_dat_i. tx_valid_o and tx_data_o hold until tx_ready_i is high.
- R6: bus_stb_o and the request fields stay unchanged while bus_stall_i is high. bus_cyc_o stays high until bus_ack_i arrives, and at most one access is outstanding.
- R7: Opcode 3 (GPIO write) takes one further byte and drives it on gpio_o from the cycle after that byte is accepted.
- R8: Opcode 4 (GPIO read) is the header byte alone. It returns one byte holding gpio_i as sampled in the cycle the header is accepted.
- R9: A header with any other opcode is consumed and has no effect: no bus access, no reply byte and no change to gpio_o. The next byte is parsed as a header.
- R10: A memory frame with a count of zero ends after its address bytes, with no bus access and no reply. The next byte is a header.
- R11: rx_ready_o is 0 whenever a bus access is in progress (bus_cyc_o high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Host byte valid |
| rx_data_i | input | 8 | Host byte |
| rx_ready_o | output | 1 | Bridge accepts a host byte |
| tx_valid_o | output | 1 | Reply byte valid |
| tx_data_o | output | 8 | Reply byte |
| tx_ready_i | input | 1 | Host accepts the reply byte |
| gpio_o | output | 8 | General-purpose output register |
| gpio_i | input | 8 | General-purpose input port |
| bus_adr_o | output | 32 | Bus word address (byte address with low bits cleared) |
| bus_dat_o | output | 32 | Bus write data |
| bus_dat_i | input | 32 | Bus read data |
| bus_sel_o | output | 4 | Bus byte select |
| bus_we_o | output | 1 | Bus write enable |
| bus_cyc_o | output | 1 | Bus cycle active |
| bus_stb_o | output | 1 | Bus request strobe |
| bus_stall_i | input | 1 | Bus not accepting the request |
| bus_ack_i | input | 1 | Bus access complete |

## Verification
The GPIO output changes on the edge that accepts its data byte. The GPIO read reply is valid one edge after the header is taken. The bench samples both at the falling edge that follows, and it changes gpio_i right after the header so that a late sample would show up. A memory access only starts two edges after its byte is accepted, and the slave model stalls for a pseudo-random number of cycles. For that reason the bench compares memory, access counts and address sequences only after a settling window of idle cycles. Read reply bytes are collected through the handshake, whenever tx_valid_o rises.

// File: rtl/cmd_bus_pkg.sv
package cmd_bus_pkg;
  localparam logic [3:0] OP_MWR = 4'h1;
  localparam logic [3:0] OP_MRD = 4'h2;
  localparam logic [3:0] OP_GWR = 4'h3;
  localparam logic [3:0] OP_GRD = 4'h4;

  typedef enum logic [2:0] {
    S_CMD, S_LEN, S_ADR, S_WDAT, S_REQ, S_BUSY, S_TX, S_GPW
  } parse_st_e;

  typedef enum logic [1:0] {
    M_IDLE, M_REQ, M_WAIT
  } bus_st_e;
endpackage

// File: rtl/cmd_bus_parser.sv
module cmd_bus_parser
  import cmd_bus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  input  logic [7:0]        gpio_i,
  output logic [7:0]        gpio_o,
  output logic              req_o,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [7:0]        req_byte_o,
  input  logic              done_i,
  input  logic [7:0]        rdata_i
);
  localparam int ABYTES = ADDR_W / 8;
  localparam int CNT_W  = (ABYTES > 1) ? $clog2(ABYTES) : 1;

  parse_st_e         st_q;
  logic [3:0]        op_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        byte_q;
  logic [7:0]        gpio_q;
  logic              rx_fire;

  assign rx_ready_o = (st_q == S_CMD) || (st_q == S_LEN) || (st_q == S_ADR) ||
                      (st_q == S_WDAT) || (st_q == S_GPW);
  assign rx_fire    = rx_valid_i && rx_ready_o;
  assign tx_valid_o = (st_q == S_TX);
  assign tx_data_o  = byte_q;
  assign gpio_o     = gpio_q;
  assign req_o      = (st_q == S_REQ);
  assign req_we_o   = (op_q == OP_MWR);
  assign req_addr_o = addr_q;
  assign req_byte_o = byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_CMD;
      op_q   <= '0;
      len_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      byte_q <= '0;
      gpio_q <= '0;
    end else begin
      case (st_q)
        S_CMD: if (rx_fire) begin
          op_q  <= rx_data_i[3:0];
          len_q <= LEN_W'(rx_data_i[7:4]) << 8;
          case (rx_data_i[3:0])
            OP_MWR, OP_MRD: st_q <= S_LEN;
            OP_GWR:         st_q <= S_GPW;
            OP_GRD: begin
              byte_q <= gpio_i;
              len_q  <= '0;   // reply path ends after one byte
              st_q   <= S_TX;
            end
            default:        st_q <= S_CMD;
          endcase
        end
        S_LEN: if (rx_fire) begin
          len_q[7:0] <= rx_data_i;
          cnt_q      <= '0;
          st_q       <= S_ADR;
        end
        S_ADR: if (rx_fire) begin
          addr_q <= {addr_q[ADDR_W-9:0], rx_data_i};
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ABYTES - 1)) begin
            if (len_q == '0)        st_q <= S_CMD;
            else if (op_q == OP_MWR) st_q <= S_WDAT;
            else                     st_q <= S_REQ;
          end
        end
        S_WDAT: if (rx_fire) begin
          byte_q <= rx_data_i;
          st_q   <= S_REQ;
        end
        S_REQ: st_q <= S_BUSY;
        S_BUSY: if (done_i) begin
          addr_q <= addr_q + 1'b1;
          len_q  <= len_q - 1'b1;
          if (op_q == OP_MRD) begin
            byte_q <= rdata_i;
            st_q   <= S_TX;
          end else begin
            st_q <= (len_q == LEN_W'(1)) ? S_CMD : S_WDAT;
          end
        end
        S_TX: if (tx_ready_i) st_q <= (len_q == '0) ? S_CMD : S_REQ;
        S_GPW: if (rx_fire) begin
          gpio_q <= rx_data_i;
          st_q   <= S_CMD;
        end
        default: st_q <= S_CMD;
      endcase
    end
  end

  p_tx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  p_gpio_on_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gpio_o) |-> $past(rx_fire));
endmodule

// File: rtl/cmd_bus_master.sv
module cmd_bus_master
  import cmd_bus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        byte_i,
  output logic              done_o,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] bus_adr_o,
  output logic [DATA_W-1:0] bus_dat_o,
  input  logic [DATA_W-1:0] bus_dat_i,
  output logic [DATA_W/8-1:0] bus_sel_o,
  output logic              bus_we_o,
  output logic              bus_cyc_o,
  output logic              bus_stb_o,
  input  logic              bus_stall_i,
  input  logic              bus_ack_i
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  bus_st_e           st_q;
  logic [ADDR_W-1:0] adr_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] dat_q;
  logic              we_q;
  logic [7:0]        lanes [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lanes[g] = bus_dat_i[8*g +: 8];
  end

  assign bus_adr_o = adr_q;
  assign bus_dat_o = dat_q;
  assign bus_we_o  = we_q;
  assign bus_sel_o = BYTES'(1) << off_q;
  assign bus_cyc_o = (st_q != M_IDLE);
  assign bus_stb_o = (st_q == M_REQ);
  assign done_o    = bus_ack_i && ((st_q == M_WAIT) || (st_q == M_REQ && !bus_stall_i));
  assign rdata_o   = lanes[off_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= M_IDLE;
      adr_q <= '0;
      off_q <= '0;
      dat_q <= '0;
      we_q  <= 1'b0;
    end else begin
      case (st_q)
        M_IDLE: if (req_i) begin
          adr_q <= {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
          off_q <= addr_i[OFF_W-1:0];
          dat_q <= {BYTES{byte_i}};
          we_q  <= we_i;
          st_q  <= M_REQ;
        end
        M_REQ: if (!bus_stall_i) st_q <= bus_ack_i ? M_IDLE : M_WAIT;
        M_WAIT: if (bus_ack_i) st_q <= M_IDLE;
        default: st_q <= M_IDLE;
      endcase
    end
  end

  p_stb_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stb_o && bus_stall_i |=> bus_stb_o && $stable(bus_adr_o) &&
    $stable(bus_sel_o) && $stable(bus_we_o) && $stable(bus_dat_o));

  p_cyc_until_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o && !bus_ack_i |=> bus_cyc_o);

  p_one_outstanding_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !bus_cyc_o);

  p_sel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stb_o |-> $countones(bus_sel_o) == 1);
endmodule

// File: rtl/cmd_bus_bridge.sv
module cmd_bus_bridge
  import cmd_bus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_valid_i,
  input  logic [7:0]          rx_data_i,
  output logic                rx_ready_o,
  output logic                tx_valid_o,
  output logic [7:0]          tx_data_o,
  input  logic                tx_ready_i,
  output logic [7:0]          gpio_o,
  input  logic [7:0]          gpio_i,
  output logic [ADDR_W-1:0]   bus_adr_o,
  output logic [DATA_W-1:0]   bus_dat_o,
  input  logic [DATA_W-1:0]   bus_dat_i,
  output logic [DATA_W/8-1:0] bus_sel_o,
  output logic                bus_we_o,
  output logic                bus_cyc_o,
  output logic                bus_stb_o,
  input  logic                bus_stall_i,
  input  logic                bus_ack_i
);
  logic              req;
  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [7:0]        req_byte;
  logic              done;
  logic [7:0]        rdata;

  cmd_bus_parser #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_parser (
    .clk_i, .rst_ni,
    .rx_valid_i, .rx_data_i, .rx_ready_o,
    .tx_valid_o, .tx_data_o, .tx_ready_i,
    .gpio_i, .gpio_o,
    .req_o(req), .req_we_o(req_we), .req_addr_o(req_addr), .req_byte_o(req_byte),
    .done_i(done), .rdata_i(rdata)
  );

  cmd_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
    .clk_i, .rst_ni,
    .req_i(req), .we_i(req_we), .addr_i(req_addr), .byte_i(req_byte),
    .done_o(done), .rdata_o(rdata),
    .bus_adr_o, .bus_dat_o, .bus_dat_i, .bus_sel_o,
    .bus_we_o, .bus_cyc_o, .bus_stb_o, .bus_stall_i, .bus_ack_i
  );

  p_no_rx_during_bus_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o |-> !rx_ready_o);

  p_no_tx_during_bus_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o |-> !tx_valid_o);
endmodule

// File: tb/tb_cmd_bus_bridge.sv
`timescale 1ns/1ps
module tb_cmd_bus_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic [7:0]  gpio_out;
  logic [7:0]  gpio_in = '0;
  logic [31:0] bus_adr, bus_dat_w, bus_dat_r;
  logic [3:0]  bus_sel;
  logic        bus_we, bus_cyc, bus_stb;
  logic        bus_stall = 1'b0;
  logic        bus_ack = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cmd_bus_bridge dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .gpio_o(gpio_out), .gpio_i(gpio_in),
    .bus_adr_o(bus_adr), .bus_dat_o(bus_dat_w), .bus_dat_i(bus_dat_r),
    .bus_sel_o(bus_sel), .bus_we_o(bus_we), .bus_cyc_o(bus_cyc), .bus_stb_o(bus_stb),
    .bus_stall_i(bus_stall), .bus_ack_i(bus_ack)
  );

  // slave memory model with pseudo-random stalls
  logic [7:0] mem     [2048];
  logic [7:0] exp_mem [2048];
  logic [7:0] lfsr = 8'h5a;
  initial for (int i = 0; i < 2048; i++) begin mem[i] = '0; exp_mem[i] = '0; end

  always @(posedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_stall <= lfsr[0] & lfsr[3];
    bus_ack   <= rst_n && bus_stb && !bus_stall;
    if (rst_n && bus_stb && !bus_stall) begin
      for (int k = 0; k < 4; k++)
        if (bus_we && bus_sel[k]) mem[{bus_adr[10:2], 2'(k)}] <= bus_dat_w[8*k +: 8];
      bus_dat_r <= {mem[{bus_adr[10:2], 2'd3}], mem[{bus_adr[10:2], 2'd2}],
                    mem[{bus_adr[10:2], 2'd1}], mem[{bus_adr[10:2], 2'd0}]};
    end
  end

  // bus monitor: address sequence, select, lanes, protocol
  logic [31:0] exp_addr = '0;
  int acc_cnt = 0;
  int mon_err4 = 0;
  int mon_err6 = 0;
  logic        prev_hold = 1'b0;
  logic [31:0] prev_adr = '0;
  logic        prev_cyc_wait = 1'b0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_hold && (!bus_stb || bus_adr != prev_adr)) mon_err6++;
      if (prev_cyc_wait && !bus_cyc) mon_err6++;
      if (bus_ack && !bus_cyc) mon_err6++;
      prev_hold     = bus_stb && bus_stall;
      prev_adr      = bus_adr;
      prev_cyc_wait = bus_cyc && !bus_ack;
      if (bus_stb && !bus_stall) begin
        acc_cnt++;
        if (bus_adr != {exp_addr[31:2], 2'b00}) mon_err4++;
        if (bus_sel != (4'b0001 << exp_addr[1:0])) mon_err4++;
        if (bus_we && !(bus_dat_w[31:24] == bus_dat_w[7:0] && bus_dat_w[23:16] == bus_dat_w[7:0] &&
                        bus_dat_w[15:8] == bus_dat_w[7:0])) mon_err4++;
        exp_addr = exp_addr + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit ok;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    forever begin
      ok = rx_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    bit v;
    @(negedge clk);
    tx_ready = 1'b1;
    forever begin
      v = tx_valid;
      b = tx_data;
      @(posedge clk);
      if (v) break;
      @(negedge clk);
    end
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic send_hdr(input logic [3:0] op, input logic [11:0] len, input logic [31:0] addr);
    send_byte({len[11:8], op});
    send_byte(len[7:0]);
    for (int i = 3; i >= 0; i--) send_byte(addr[8*i +: 8]);
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rx_ready == 1'b1, "R1", "rx_ready", rx_ready, 1);
    chk(tx_valid == 1'b0, "R1", "tx_valid", tx_valid, 0);
    chk({bus_cyc, bus_stb} == 2'b00, "R1", "cyc/stb", {bus_cyc, bus_stb}, 0);
    chk(gpio_out == 8'h00, "R1", "gpio_o", gpio_out, 0);
  endtask

  task automatic t_mem_write(input logic [31:0] addr, input int len, input int seed);
    int base = acc_cnt;
    int bad = 0;
    int e4 = mon_err4;
    int e6 = mon_err6;
    logic [7:0] d;
    exp_addr = addr;
    send_hdr(4'h1, 12'(len), addr);
    for (int i = 0; i < len; i++) begin
      d = 8'(i * 7 + seed);
      exp_mem[11'(addr + i)] = d;
      send_byte(d);
    end
    settle();
    for (int i = 0; i < 2048; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, "R3", "mismatching bytes", bad, 0);
    chk(acc_cnt - base == len, "R4", "bus accesses", acc_cnt - base, len);
    chk(mon_err4 == e4, "R4", "adr/sel/lane errors (R2 address bits)", mon_err4 - e4, 0);
    chk(mon_err6 == e6, "R6", "protocol errors", mon_err6 - e6, 0);
  endtask

  task automatic t_mem_read(input logic [31:0] addr, input int len);
    int base = acc_cnt;
    int bad = 0;
    logic [7:0] b;
    exp_addr = addr;
    send_hdr(4'h2, 12'(len), addr);
    for (int i = 0; i < len; i++) begin
      recv_byte(b);
      if (b !== exp_mem[11'(addr + i)]) begin
        bad++;
        $display("FAIL R5 byte %0d: actual %0h expected %0h", i, b, exp_mem[11'(addr + i)]);
      end
    end
    settle();
    checks++;
    if (bad != 0) errors++;
    chk(acc_cnt - base == len, "R5", "read accesses", acc_cnt - base, len);
    chk(tx_valid == 1'b0, "R5", "extra reply byte", tx_valid, 0);
  endtask

  task automatic t_gpio_write(input logic [7:0] v);
    send_byte(8'h03);
    send_byte(v);  // returns at the falling edge after acceptance
    chk(gpio_out == v, "R7", "gpio_o", gpio_out, v);
  endtask

  task automatic t_gpio_read(input logic [7:0] v);
    logic [7:0] b;
    gpio_in = v;
    send_byte(8'h04);
    gpio_in = ~v;  // later changes must not reach the reply
    recv_byte(b);
    chk(b == v, "R8", "gpio read reply", b, v);
  endtask

  task automatic t_bad_op(input logic [7:0] hdr);
    int base = acc_cnt;
    logic [7:0] g = gpio_out;
    bit saw_tx = 0;
    send_byte(hdr);
    repeat (10) begin @(negedge clk); if (tx_valid) saw_tx = 1; end
    chk(acc_cnt == base, "R9", "bus accesses after bad opcode", acc_cnt - base, 0);
    chk(!saw_tx, "R9", "reply after bad opcode", saw_tx, 0);
    chk(gpio_out == g, "R9", "gpio_o after bad opcode", gpio_out, g);
    t_gpio_read(8'hc3);  // next byte must be a header
  endtask

  task automatic t_zero_len(input logic [3:0] op);
    int base = acc_cnt;
    bit saw_tx = 0;
    send_hdr(op, 12'd0, 32'h0000_0040);
    repeat (10) begin @(negedge clk); if (tx_valid) saw_tx = 1; end
    chk(acc_cnt == base, "R10", "accesses for zero count", acc_cnt - base, 0);
    chk(!saw_tx, "R10", "reply for zero count", saw_tx, 0);
    t_gpio_write(8'h5e);  // next byte must be a header
  endtask

  task automatic t_busy_ready();
    int bad = 0;
    fork
      t_mem_write(32'h0000_0600, 20, 11);
      repeat (200) begin @(negedge clk); if (bus_cyc && rx_ready) bad++; end
    join
    chk(bad == 0, "R11", "rx_ready high during access", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mem_write(32'hA512_0100, 16, 1);
    t_mem_write(32'h3C00_0201, 14, 9);      // unaligned start
    t_mem_write(32'h0000_0300, 12'h105, 3); // count above 255
    t_mem_read(32'hA512_0100, 16);
    t_mem_read(32'h7700_0203, 9);           // unaligned read
    t_gpio_write(8'ha6);
    t_gpio_write(8'h00);
    t_gpio_read(8'h55);
    t_gpio_read(8'h81);
    t_bad_op(8'h07);
    t_bad_op(8'hf0);
    t_zero_len(4'h1);
    t_zero_len(4'h2);
    t_busy_ready();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule